// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This block keeps an asynchronous 16-bit EDO DRAM with nine multiplexed address lines alive. After reset it blocks all traffic for a power-up pause. It then runs a set of warm-up refresh cycles. From then on it produces refresh work at a fixed interval and performs each unit of work as a refresh cycle that drops CAS before RAS, so the memory's own row counter supplies the row. The address lines and data pins are left alone throughout.

The block shares the strobe pins with an access sequencer through a level handshake. It raises `refReq`, and the access sequencer answers with `refGrant` once it is idle with RAS precharged. The block then owns the strobes (`busOwn` high) for one whole cycle, precharge included. Refresh work that cannot be served is counted as debt, up to a limit. When the debt reaches that limit, `urgent` tells the access sequencer to cut short its page bursts. `ready` tells the rest of the system that normal accesses may begin.

All timing limits are given in nanoseconds and turned into clock counts by rounding up at the configured clock period.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted and right after it: `rasN`, `lcasN`, `ucasN`, `weN` and `oeN` are high, and `refReq`, `busOwn`, `ready` and `urgent` are low.
- R2: After reset is released, `refReq` stays low for exactly ceil(PAUSE_NS/CLK_NS) cycles and rises on the next one. No refresh cycle starts during the pause.
- R3: In every refresh cycle, `lcasN` and `ucasN` fall together exactly ceil(CSR_NS/CLK_NS) cycles before `rasN` falls. `weN` and `oeN` stay high at all times.
- R4: CAS stays low for exactly ceil(CHR_NS/CLK_NS) cycles after `rasN` falls, then rises while `rasN` is still low.
- R5: `rasN` stays low for exactly max(ceil(RAS_NS/CLK_NS), ceil(CHR_NS/CLK_NS)+1) cycles. Between two refresh cycles, `rasN` stays high for at least max(ceil(RP_NS/CLK_NS), ceil(RPC_NS/CLK_NS)) cycles. Successive RAS falls are at least ceil(RC_NS/CLK_NS) cycles apart.
- R6: A refresh cycle starts (`busOwn` rises) only if `refGrant` was high in the cycle before. `busOwn` stays high from the first CAS fall through the end of the precharge. While `busOwn` is low, all strobes are high.
- R7: After the pause, exactly WARM_CYCLES refresh cycles run. `ready` rises at the end of the last one and never falls until reset.
- R8: Once `ready` is high, one unit of refresh debt is added every ceil(INTERVAL_NS/CLK_NS) cycles. The first unit is added that many cycles after `ready` rises. `refReq` is high while debt is nonzero or a cycle is in progress. With `refGrant` held high, one refresh cycle runs per interval.
- R9: Debt saturates at DEBT_MAX (8 by default), and interval ticks beyond the limit are dropped. `urgent` is high exactly while the debt equals DEBT_MAX. Granting a saturated block yields exactly DEBT_MAX refresh cycles before `refReq` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refGrant | input | 1 | Access sequencer is idle and precharged; the strobes may be taken |
| refReq | output | 1 | Refresh work pending or in progress |
| busOwn | output | 1 | The block drives the DRAM strobes in this cycle |
| ready | output | 1 | Initialization finished; normal accesses allowed |
| urgent | output | 1 | Refresh debt saturated; page bursts should be preempted |
| rasN | output | 1 | Row strobe, active low |
| lcasN | output | 1 | Lower-byte column strobe, active low |
| ucasN | output | 1 | Upper-byte column strobe, active low |
| weN | output | 1 | Write enable, held high |
| oeN | output | 1 | Output enable, held high |

## Verification
A phase counter loaded with the wrong length shows at the strobe pins within one refresh cycle. It appears as a wrong CAS lead, a wrong CAS hold or a wrong RAS width, all measured in whole clocks at each RAS edge. A fault in the pause, warm-up or interval timers shows as a `refReq`, `ready` or `urgent` edge in the wrong cycle. These edges are checked in the exact cycle the requirements predict, so a one-cycle slip is caught. A wrong debt count shows when a saturated block is drained: the number of RAS falls before `refReq` drops is counted against DEBT_MAX.

// File: rtl/dref_pkg.sv
`timescale 1ns/1ps
package dref_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_SETUP   = 3'd1,
    PH_HOLD    = 3'd2,
    PH_RASONLY = 3'd3,
    PH_PRE     = 3'd4
  } phase_e;

  // Strobes from the control FSM to the timer datapath.
  typedef struct packed {
    logic   load;     // load the phase counter for phase 'sel'
    phase_e sel;
    logic   doneRef;  // a refresh cycle finished this clock
  } strobe_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int maxI(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dref_datapath.sv
`timescale 1ns/1ps
module dref_datapath
  import dref_pkg::*;
#(
  parameter int CLK_NS      = 5,
  parameter int PAUSE_NS    = 200000,
  parameter int INTERVAL_NS = 15600,
  parameter int WARM_CYCLES = 8,
  parameter int DEBT_MAX    = 8,
  parameter int CSR_NS      = 5,
  parameter int CHR_NS      = 6,
  parameter int RAS_NS      = 28,
  parameter int RP_NS       = 17,
  parameter int RC_NS       = 48,
  parameter int RPC_NS      = 0
) (
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t stb,
  output logic    pauseDone,
  output logic    phaseDone,
  output logic    debtNonZero,
  output logic    debtFull,
  output logic    readyOut
);

  // Cycle counts, rounded up at the clock period.
  localparam int PAUSE_C  = maxI(ceilDiv(PAUSE_NS, CLK_NS), 1);
  localparam int INT_C    = maxI(ceilDiv(INTERVAL_NS, CLK_NS), 1);
  localparam int CSR_C    = maxI(ceilDiv(CSR_NS, CLK_NS), 1);
  localparam int CHR_C    = maxI(ceilDiv(CHR_NS, CLK_NS), 1);
  localparam int RASLOW_C = maxI(ceilDiv(RAS_NS, CLK_NS), CHR_C + 1);
  localparam int ONLY_C   = RASLOW_C - CHR_C;
  localparam int PRE_C    = maxI(maxI(ceilDiv(RP_NS, CLK_NS), ceilDiv(RPC_NS, CLK_NS)),
                                 maxI(ceilDiv(RC_NS, CLK_NS) - RASLOW_C, 1));
  localparam int PHMAX_C  = maxI(maxI(CSR_C, CHR_C), maxI(ONLY_C, PRE_C));

  localparam int PW  = $clog2(PAUSE_C + 1);
  localparam int IW  = $clog2(INT_C + 1);
  localparam int PHW = $clog2(PHMAX_C + 1);
  localparam int DW  = $clog2(DEBT_MAX + 1);
  localparam int WW  = $clog2(WARM_CYCLES + 1);

  localparam logic [PW-1:0]  PAUSE_LAST = PW'(PAUSE_C - 1);
  localparam logic [IW-1:0]  INT_LAST   = IW'(INT_C - 1);
  localparam logic [DW-1:0]  DEBT_TOP   = DW'(DEBT_MAX);
  localparam logic [WW-1:0]  WARM_INIT  = WW'(WARM_CYCLES);

  // Power-up pause
  logic [PW-1:0] pauseCnt;
  logic          pauseQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pauseCnt <= '0;
      pauseQ   <= 1'b0;
    end else if (!pauseQ) begin
      if (pauseCnt == PAUSE_LAST) pauseQ <= 1'b1;
      else                        pauseCnt <= pauseCnt + 1'b1;
    end
  end
  assign pauseDone = pauseQ;

  // Warm-up cycle counter; ready once it reaches zero
  logic [WW-1:0] warmLeft;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   warmLeft <= WARM_INIT;
    else if (stb.doneRef && (warmLeft != '0))    warmLeft <= warmLeft - 1'b1;
  end
  assign readyOut = (warmLeft == '0);

  // Refresh interval timer, runs once ready
  logic [IW-1:0] intCnt;
  logic          tick;
  assign tick = readyOut && (intCnt == INT_LAST);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          intCnt <= '0;
    else if (!readyOut) intCnt <= '0;
    else if (tick)      intCnt <= '0;
    else                intCnt <= intCnt + 1'b1;
  end

  // Refresh debt, saturating
  logic [DW-1:0] debt;
  logic          payDebt;
  assign payDebt     = stb.doneRef && readyOut;
  assign debtNonZero = (debt != '0);
  assign debtFull    = (debt == DEBT_TOP);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) debt <= '0;
    else begin
      case ({tick, payDebt})
        2'b10:   if (!debtFull)   debt <= debt + 1'b1;
        2'b01:   if (debtNonZero) debt <= debt - 1'b1;
        default: debt <= debt;
      endcase
    end
  end

  // Phase length counter
  logic [PHW-1:0] phCnt;
  logic [PHW-1:0] phLoad;
  always_comb begin
    case (stb.sel)
      PH_SETUP:   phLoad = PHW'(CSR_C - 1);
      PH_HOLD:    phLoad = PHW'(CHR_C - 1);
      PH_RASONLY: phLoad = PHW'(ONLY_C - 1);
      PH_PRE:     phLoad = PHW'(PRE_C - 1);
      default:    phLoad = '0;
    endcase
  end
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              phCnt <= '0;
    else if (stb.load)      phCnt <= phLoad;
    else if (phCnt != '0)   phCnt <= phCnt - 1'b1;
  end
  assign phaseDone = (phCnt == '0);

  // R7: ready is sticky
  assert_ready_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    readyOut |=> readyOut);

  // R9: a tick on a full account leaves it full
  assert_debt_saturate_R9: assert property (@(posedge clk) disable iff (!rstN)
    (debtFull && tick && !payDebt) |=> debtFull);

  // R8: no debt accrues before ready
  assert_no_debt_early_R8: assert property (@(posedge clk) disable iff (!rstN)
    !readyOut |=> !debtNonZero);

endmodule

// File: rtl/dref_ctrl.sv
`timescale 1ns/1ps
module dref_ctrl
  import dref_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    refGrant,
  input  logic    pauseDone,
  input  logic    phaseDone,
  input  logic    debtNonZero,
  input  logic    readyIn,
  output strobe_t stb,
  output logic    refReq,
  output logic    busOwn,
  output logic    rasN,
  output logic    lcasN,
  output logic    ucasN,
  output logic    weN,
  output logic    oeN
);

  phase_e state, stateNext;
  logic   rasQ, casQ, busQ;
  logic   pending;

  assign pending = pauseDone && (!readyIn || debtNonZero);

  always_comb begin
    stateNext = state;
    stb       = '{load: 1'b0, sel: PH_IDLE, doneRef: 1'b0};
    case (state)
      PH_IDLE: if (pending && refGrant) begin
        stateNext = PH_SETUP;
        stb.load  = 1'b1;
        stb.sel   = PH_SETUP;
      end
      PH_SETUP: if (phaseDone) begin
        stateNext = PH_HOLD;
        stb.load  = 1'b1;
        stb.sel   = PH_HOLD;
      end
      PH_HOLD: if (phaseDone) begin
        stateNext = PH_RASONLY;
        stb.load  = 1'b1;
        stb.sel   = PH_RASONLY;
      end
      PH_RASONLY: if (phaseDone) begin
        stateNext = PH_PRE;
        stb.load  = 1'b1;
        stb.sel   = PH_PRE;
      end
      PH_PRE: if (phaseDone) begin
        stateNext   = PH_IDLE;
        stb.doneRef = 1'b1;
      end
      default: stateNext = PH_IDLE;
    endcase
  end

  // Strobes are registered from the next state: glitch-free pins.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= PH_IDLE;
      rasQ  <= 1'b1;
      casQ  <= 1'b1;
      busQ  <= 1'b0;
    end else begin
      state <= stateNext;
      busQ  <= (stateNext != PH_IDLE);
      rasQ  <= !((stateNext == PH_HOLD) || (stateNext == PH_RASONLY));
      casQ  <= !((stateNext == PH_SETUP) || (stateNext == PH_HOLD));
    end
  end

  assign refReq = busQ || pending;
  assign busOwn = busQ;
  assign rasN   = rasQ;
  assign lcasN  = casQ;
  assign ucasN  = casQ;
  assign weN    = 1'b1;
  assign oeN    = 1'b1;

  // R3: RAS only falls with CAS already low
  assert_cas_lead_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasQ) |-> $past(!casQ));

  // R4: CAS returns high while RAS is still low
  assert_cas_release_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(casQ) && !$past(rasQ)) |-> !rasQ);

  // R6: a cycle starts only after a grant
  assert_grant_start_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busQ) |-> $past(refGrant));

  // R2: no bus ownership during the pause
  assert_no_own_in_pause_R2: assert property (@(posedge clk) disable iff (!rstN)
    !pauseDone |-> !busQ);

endmodule

// File: rtl/dram_refresh_seq.sv
`timescale 1ns/1ps
module dram_refresh_seq
  import dref_pkg::*;
#(
  parameter int CLK_NS      = 5,
  parameter int PAUSE_NS    = 200000,
  parameter int INTERVAL_NS = 15600,
  parameter int WARM_CYCLES = 8,
  parameter int DEBT_MAX    = 8,
  parameter int CSR_NS      = 5,
  parameter int CHR_NS      = 6,
  parameter int RAS_NS      = 28,
  parameter int RP_NS       = 17,
  parameter int RC_NS       = 48,
  parameter int RPC_NS      = 0
) (
  input  logic clk,
  input  logic rstN,
  input  logic refGrant,
  output logic refReq,
  output logic busOwn,
  output logic ready,
  output logic urgent,
  output logic rasN,
  output logic lcasN,
  output logic ucasN,
  output logic weN,
  output logic oeN
);

  strobe_t stb;
  logic    pauseDone, phaseDone, debtNonZero, debtFull, readyInt;

  dref_datapath #(
    .CLK_NS(CLK_NS), .PAUSE_NS(PAUSE_NS), .INTERVAL_NS(INTERVAL_NS),
    .WARM_CYCLES(WARM_CYCLES), .DEBT_MAX(DEBT_MAX),
    .CSR_NS(CSR_NS), .CHR_NS(CHR_NS), .RAS_NS(RAS_NS),
    .RP_NS(RP_NS), .RC_NS(RC_NS), .RPC_NS(RPC_NS)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .stb(stb),
    .pauseDone(pauseDone), .phaseDone(phaseDone),
    .debtNonZero(debtNonZero), .debtFull(debtFull), .readyOut(readyInt)
  );

  dref_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .refGrant(refGrant),
    .pauseDone(pauseDone), .phaseDone(phaseDone),
    .debtNonZero(debtNonZero), .readyIn(readyInt),
    .stb(stb), .refReq(refReq), .busOwn(busOwn),
    .rasN(rasN), .lcasN(lcasN), .ucasN(ucasN), .weN(weN), .oeN(oeN)
  );

  assign ready  = readyInt;
  assign urgent = debtFull;

endmodule

// File: tb/test_dram_refresh_seq.sv
`timescale 1ns/1ps
module test_dram_refresh_seq;

  localparam int CLK_NS  = 5;
  localparam int PAUSE_NS = 1000;
  localparam int INTV_NS  = 1000;
  localparam int WARM     = 8;
  localparam int DMAX     = 8;

  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int P_E      = cdiv(PAUSE_NS, CLK_NS);
  localparam int I_E      = cdiv(INTV_NS, CLK_NS);
  localparam int CSR_E    = cdiv(5, CLK_NS);
  localparam int CHR_E    = cdiv(6, CLK_NS);
  localparam int RASLOW_E = mx(cdiv(28, CLK_NS), CHR_E + 1);
  localparam int RP_E     = mx(cdiv(17, CLK_NS), 0);
  localparam int RC_E     = cdiv(48, CLK_NS);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refGrant = 1'b0;
  logic refReq, busOwn, ready, urgent, rasN, lcasN, ucasN, weN, oeN;

  always #2.5 clk = ~clk;

  dram_refresh_seq #(.CLK_NS(CLK_NS), .PAUSE_NS(PAUSE_NS), .INTERVAL_NS(INTV_NS))
  i_dram_refresh_seq (
    .clk(clk), .rstN(rstN), .refGrant(refGrant), .refReq(refReq),
    .busOwn(busOwn), .ready(ready), .urgent(urgent), .rasN(rasN),
    .lcasN(lcasN), .ucasN(ucasN), .weN(weN), .oeN(oeN)
  );

  int vectors = 0;
  int misses  = 0;
  int cyc     = 0;
  int relCyc  = 0;
  int readyCyc = 0;
  int rasFallCnt = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic waitCyc(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  // Pin monitor: strobe widths measured in whole clocks
  logic prevRas = 1'b1, prevCas = 1'b1;
  int tCasFall = 0, tRasFall = 0, tRasRise = -1, tPrevRasFall = -1;
  always @(negedge clk) begin
    if (rstN) begin
      if (!(weN && oeN && (lcasN == ucasN)))
        chk(1'b0, "R3 we/oe high, cas pair equal", {weN, oeN}, 3);
      if (!busOwn && !(rasN && lcasN))
        chk(1'b0, "R6 strobes idle without ownership", {rasN, lcasN}, 3);
      if (prevCas && !lcasN) tCasFall = cyc;
      if (prevRas && !rasN) begin
        rasFallCnt++;
        tRasFall = cyc;
        chk(cyc - tCasFall == CSR_E, "R3 cas lead before ras", cyc - tCasFall, CSR_E);
        if (tRasRise >= 0)
          chk(cyc - tRasRise >= RP_E, "R5 ras precharge", cyc - tRasRise, RP_E);
        if (tPrevRasFall >= 0)
          chk(cyc - tPrevRasFall >= RC_E, "R5 ras cycle", cyc - tPrevRasFall, RC_E);
        tPrevRasFall = cyc;
      end
      if (!prevCas && lcasN && !rasN)
        chk(cyc - tRasFall == CHR_E, "R4 cas hold after ras", cyc - tRasFall, CHR_E);
      if (!prevCas && lcasN && rasN)
        chk(1'b0, "R4 cas rose with ras high", 1, 0);
      if (!prevRas && rasN) begin
        tRasRise = cyc;
        chk(cyc - tRasFall == RASLOW_E, "R5 ras low width", cyc - tRasFall, RASLOW_E);
      end
      prevRas = rasN;
      prevCas = lcasN;
    end
  end

  task automatic t_reset;
    repeat (4) @(negedge clk);
    chk(rasN && lcasN && ucasN && weN && oeN, "R1 strobes high in reset",
        {rasN, lcasN, ucasN, weN, oeN}, 31);
    chk(!refReq && !busOwn && !ready && !urgent, "R1 outputs low in reset",
        {refReq, busOwn, ready, urgent}, 0);
    rstN = 1'b1;
    relCyc = cyc;
    @(negedge clk);
    chk(!refReq && !busOwn && !ready, "R1 outputs low after release",
        {refReq, busOwn, ready}, 0);
  endtask

  task automatic t_pause;
    waitCyc(relCyc + P_E - 1);
    chk(!refReq, "R2 refReq low at end of pause", refReq, 0);
    @(negedge clk);
    chk(refReq, "R2 refReq rises after pause", refReq, 1);
    repeat (20) @(negedge clk);
    chk(!busOwn && rasN && lcasN, "R6 no cycle without grant", busOwn, 0);
    refGrant = 1'b1;
  endtask

  task automatic t_warm;
    int guard = 0;
    rasFallCnt = 0;
    while (!ready && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    readyCyc = cyc;
    chk(ready, "R7 ready reached", ready, 1);
    chk(rasFallCnt == WARM, "R7 warm-up cycle count", rasFallCnt, WARM);
    chk(!refReq && !busOwn, "R8 refReq low with no debt", refReq, 0);
    refGrant = 1'b0;
  endtask

  task automatic t_debt;
    int guard = 0;
    waitCyc(readyCyc + I_E - 1);
    chk(!refReq, "R8 no debt before first interval", refReq, 0);
    @(negedge clk);
    chk(refReq, "R8 debt after first interval", refReq, 1);
    waitCyc(readyCyc + DMAX * I_E - 1);
    chk(!urgent, "R9 urgent low one short of limit", urgent, 0);
    @(negedge clk);
    chk(urgent, "R9 urgent high at limit", urgent, 1);
    waitCyc(readyCyc + 10 * I_E);
    chk(urgent && !busOwn, "R9 saturated and waiting for grant", {urgent, busOwn}, 2);
    refGrant = 1'b1;
    rasFallCnt = 0;
    while (refReq && guard < 1000) begin
      @(negedge clk);
      guard++;
      if (rasFallCnt == 2)
        chk(!urgent, "R9 urgent clears after a refresh", urgent, 0);
    end
    chk(rasFallCnt == DMAX, "R9 drain count", rasFallCnt, DMAX);
    chk(!urgent && !refReq, "R9 idle after drain", {urgent, refReq}, 0);
  endtask

  task automatic t_steady;
    waitCyc(readyCyc + 12 * I_E + 50);
    rasFallCnt = 0;
    waitCyc(readyCyc + 17 * I_E + 50);
    chk(rasFallCnt == 5, "R8 one refresh per interval", rasFallCnt, 5);
    chk(ready, "R7 ready stays high", ready, 1);
  endtask

  initial begin
    t_reset();
    t_pause();
    t_warm();
    t_debt();
    t_steady();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    while (cyc < 20000) @(posedge clk);
    if (!done) begin
      vectors++;
      misses++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule